// File: doc/BRIEF.md
# Audio Sample Word Formatter

This block sits between a transmit sample FIFO and a biphase line encoder. Each time the encoder asks for a subframe, the block takes the 32-bit word at the head of a show-ahead FIFO and splits it into the subframe fields. These fields are a 24-bit audio payload, a 4-bit auxiliary nibble, a 4-bit preamble code, and the validity, user, channel-status and parity bits. A 2-bit mode input and a pack input select how the host word is read.

The encoder raises a request and marks it as the left or the right subframe with a channel input. In the packed 16-bit format one host word carries both channels. The block then reads the low half for the left request and the high half for the right request, and it releases the word only after the right subframe has been formatted. In the other formats every request uses a whole word. When a word is needed but the FIFO is empty, the block reports an underrun and emits a silent subframe.

Top module: `sample_word_fmt`

## Requirements
- R1: Mode code 2 (`bit_mode_i`=10) is 24-bit: payload = word[23:0], word[31:24] ignored, aux = 0.
- R2: Mode code 0 (00) is 16-bit: payload = {word[15:0], 8'h00}; word[31:16] ignored when unpacked.
- R3: Mode code 1 (01) is 20-bit: payload = {word[19:0], 4'h0}, aux = 0.
- R4: Mode code 3 (11) is raw: parity = word[31], channel status = word[30], user = word[29], validity = word[28], payload = {word[27:8], 4'h0}, aux = word[7:4], preamble = word[3:0], all passed through unchanged.
- R5: With `pack_i`=1 and 16-bit mode, a left request (`chan_i`=0) yields {word[15:0],8'h00} without popping, and a right request (`chan_i`=1) yields {word[31:16],8'h00} and pops the word.
- R6: `pack_i`=1 with any mode other than 16-bit behaves exactly as the unpacked format, popping on every request.
- R7: Outside raw mode validity, user and channel status are 0, and parity makes the XOR of payload, aux, V, U, C and P equal to 0 (even parity over time slots 4 to 31).
- R8: Outside raw mode the preamble code is 4'h1 for a left subframe and 4'h2 for a right subframe; an underrun subframe also uses these codes.
- R9: A request that needs a word while `fifo_empty_i`=1 gives a one-cycle `underrun_o` pulse with the subframe, zero payload, aux, V, U, C and P, and no pop.
- R10: The subframe outputs and `sf_valid_o` are registered and appear in the cycle after the request; `fifo_pop_o` is asserted in the request cycle itself.
- R11: During reset and until the first request, `sf_valid_o`, `underrun_o` and all subframe field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_mode_i | input | 2 | Sample format: 0=16-bit, 1=20-bit, 2=24-bit, 3=raw |
| pack_i | input | 1 | Two 16-bit channels per word |
| sf_req_i | input | 1 | Encoder requests one subframe |
| chan_i | input | 1 | Requested subframe: 0=left, 1=right |
| fifo_word_i | input | 32 | Head word of the transmit FIFO |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Consume the head word |
| sf_valid_o | output | 1 | Subframe fields valid this cycle |
| payload_o | output | 24 | Audio payload, MSB-aligned |
| aux_o | output | 4 | Auxiliary nibble |
| preamble_o | output | 4 | Preamble code |
| valid_bit_o | output | 1 | Validity bit |
| user_bit_o | output | 1 | User bit |
| cstat_bit_o | output | 1 | Channel-status bit |
| parity_o | output | 1 | Parity bit |
| underrun_o | output | 1 | Word needed while FIFO empty |

## Verification
Each format gets a word whose unused upper bits are all ones, so a formatter that fails to mask them or misaligns the sample shows up as a payload mismatch. In the packed tests the two halves of each word differ, which separates a half-swap from a missed or early pop. The same pack request is then repeated in 24-bit mode, which shows whether packing leaks into other formats. Raw words carry a deliberately wrong parity bit and mixed P/C/U/V values, so pass-through can be told apart from regeneration. The empty-FIFO requests are made on both channels and in packed mode.

// File: rtl/sample_word_fmt_pkg.sv
package sample_word_fmt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAY_W  = 24;
  localparam int unsigned AUX_W  = 4;
  localparam int unsigned PRE_W  = 4;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    MODE_16  = 2'd0,
    MODE_20  = 2'd1,
    MODE_24  = 2'd2,
    MODE_RAW = 2'd3
  } bit_mode_e;

  localparam logic [PRE_W-1:0] PRE_LEFT  = 4'h1;
  localparam logic [PRE_W-1:0] PRE_RIGHT = 4'h2;

  typedef struct packed {
    logic [PAY_W-1:0] payload;
    logic [AUX_W-1:0] aux;
    logic [PRE_W-1:0] pre;
    logic             v;
    logic             u;
    logic             c;
    logic             p;
  } subframe_t;
endpackage

// File: rtl/sample_word_seq.sv
module sample_word_seq
  import sample_word_fmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       chan_i,
  input  bit_mode_e  mode_i,
  input  logic       pack_i,
  input  logic       empty_i,
  output logic       packed_o,
  output logic       starve_o,
  output logic       pop_o
);
  // packing is only legal with 16-bit samples
  assign packed_o = pack_i && (mode_i == MODE_16);
  assign starve_o = req_i && empty_i;
  assign pop_o    = req_i && !empty_i && (!packed_o || chan_i);

  p_pop_not_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> !empty_i);
  p_packed_left_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && packed_o && !chan_i) |-> !pop_o);
  p_unpacked_pops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !empty_i && !packed_o) |-> pop_o);
endmodule

// File: rtl/sample_word_decode.sv
module sample_word_decode
  import sample_word_fmt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  bit_mode_e         mode_i,
  input  logic              packed_i,
  input  logic              chan_i,
  input  logic              starve_i,
  output subframe_t         sf_o
);
  logic [HALF_W-1:0] s16;

  always_comb begin
    s16 = (packed_i && chan_i) ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];
    sf_o = '0;
    sf_o.pre = chan_i ? PRE_RIGHT : PRE_LEFT;
    if (!starve_i) begin
      unique case (mode_i)
        MODE_16: sf_o.payload = {s16, 8'h00};
        MODE_20: sf_o.payload = {word_i[19:0], 4'h0};
        MODE_24: sf_o.payload = word_i[23:0];
        MODE_RAW: begin
          sf_o.p       = word_i[31];
          sf_o.c       = word_i[30];
          sf_o.u       = word_i[29];
          sf_o.v       = word_i[28];
          sf_o.payload = {word_i[27:8], 4'h0};
          sf_o.aux     = word_i[7:4];
          sf_o.pre     = word_i[3:0];
        end
        default: sf_o.payload = '0;
      endcase
    end
  end
endmodule

// File: rtl/sample_word_parity.sv
module sample_word_parity
  import sample_word_fmt_pkg::*;
(
  input  subframe_t sf_i,
  input  logic      raw_i,
  output subframe_t sf_o
);
  always_comb begin
    sf_o = sf_i;
    if (!raw_i) sf_o.p = ^{sf_i.payload, sf_i.aux, sf_i.v, sf_i.u, sf_i.c};
  end
endmodule

// File: rtl/sample_word_fmt.sv
module sample_word_fmt
  import sample_word_fmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  bit_mode_i,
  input  logic        pack_i,
  input  logic        sf_req_i,
  input  logic        chan_i,
  input  logic [31:0] fifo_word_i,
  input  logic        fifo_empty_i,
  output logic        fifo_pop_o,
  output logic        sf_valid_o,
  output logic [23:0] payload_o,
  output logic [3:0]  aux_o,
  output logic [3:0]  preamble_o,
  output logic        valid_bit_o,
  output logic        user_bit_o,
  output logic        cstat_bit_o,
  output logic        parity_o,
  output logic        underrun_o
);
  bit_mode_e mode;
  logic      is_packed, starve;
  subframe_t sf_dec, sf_par, sf_q;
  logic      valid_q, under_q, raw_q;

  assign mode = bit_mode_e'(bit_mode_i);

  sample_word_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (sf_req_i),
    .chan_i   (chan_i),
    .mode_i   (mode),
    .pack_i   (pack_i),
    .empty_i  (fifo_empty_i),
    .packed_o (is_packed),
    .starve_o (starve),
    .pop_o    (fifo_pop_o)
  );

  sample_word_decode u_dec (
    .word_i   (fifo_word_i),
    .mode_i   (mode),
    .packed_i (is_packed),
    .chan_i   (chan_i),
    .starve_i (starve),
    .sf_o     (sf_dec)
  );

  sample_word_parity u_par (
    .sf_i  (sf_dec),
    .raw_i (mode == MODE_RAW && !starve),
    .sf_o  (sf_par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sf_q    <= '0;
      valid_q <= 1'b0;
      under_q <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      valid_q <= sf_req_i;
      under_q <= starve;
      if (sf_req_i) begin
        sf_q  <= sf_par;
        raw_q <= (mode == MODE_RAW) && !starve;
      end
    end
  end

  assign sf_valid_o  = valid_q;
  assign underrun_o  = under_q;
  assign payload_o   = sf_q.payload;
  assign aux_o       = sf_q.aux;
  assign preamble_o  = sf_q.pre;
  assign valid_bit_o = sf_q.v;
  assign user_bit_o  = sf_q.u;
  assign cstat_bit_o = sf_q.c;
  assign parity_o    = sf_q.p;

  p_valid_after_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_req_i |=> sf_valid_o);
  p_underrun_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (sf_valid_o && payload_o == '0 && aux_o == '0 && !parity_o));
  p_underrun_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !$past(sf_req_i)) |-> 1'b0);
  p_even_parity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_o && !raw_q) |-> (^{payload_o, aux_o, valid_bit_o, user_bit_o,
                                  cstat_bit_o, parity_o} == 1'b0));
  p_flags_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_o && !raw_q) |-> !(valid_bit_o || user_bit_o || cstat_bit_o));
endmodule

// File: tb/tb_sample_word_fmt.sv
`timescale 1ns/1ps
module tb_sample_word_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bit_mode = 2'd0;
  logic        pack = 1'b0;
  logic        req = 1'b0;
  logic        chan = 1'b0;
  logic [31:0] fifo_word = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic        sf_valid, v_b, u_b, c_b, p_b, underrun;
  logic [23:0] payload;
  logic [3:0]  aux, pre;

  int total = 0;
  int bad = 0;
  logic [31:0] hq[$];
  logic [36:0] expq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  sample_word_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_mode_i(bit_mode), .pack_i(pack),
    .sf_req_i(req), .chan_i(chan), .fifo_word_i(fifo_word),
    .fifo_empty_i(fifo_empty), .fifo_pop_o(fifo_pop), .sf_valid_o(sf_valid),
    .payload_o(payload), .aux_o(aux), .preamble_o(pre), .valid_bit_o(v_b),
    .user_bit_o(u_b), .cstat_bit_o(c_b), .parity_o(p_b), .underrun_o(underrun)
  );

  function automatic logic [36:0] pack_obs();
    return {underrun, payload, aux, pre, v_b, u_b, c_b, p_b};
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (hq.size() == 0);
    fifo_word  = fifo_empty ? 32'hFFFF_FFFF : hq[0];
  endtask

  // expected subframe built from the requirements
  function automatic logic [36:0] model(input logic [31:0] w, input logic [1:0] m,
                                        input logic pk, input logic ch, input logic emp);
    logic [23:0] pl; logic [3:0] ax, pr; logic v, u, c, p;
    pl = '0; ax = '0; v = 0; u = 0; c = 0;
    pr = ch ? 4'h2 : 4'h1;
    if (emp) return {1'b1, 24'h0, 4'h0, pr, 4'h0};
    case (m)
      2'd0: pl = (pk && ch) ? {w[31:16], 8'h00} : {w[15:0], 8'h00};
      2'd1: pl = {w[19:0], 4'h0};
      2'd2: pl = w[23:0];
      default: begin
        return {1'b0, w[27:8], 4'h0, w[7:4], w[3:0], w[28], w[29], w[30], w[31]};
      end
    endcase
    p = ^{pl, ax};
    return {1'b0, pl, ax, pr, v, u, c, p};
  endfunction

  task automatic do_sf(input logic ch, input string tag);
    logic exp_pop, pk_eff;
    @(negedge clk);
    req  = 1'b1;
    chan = ch;
    pk_eff  = pack && (bit_mode == 2'd0);
    exp_pop = !fifo_empty && (!pk_eff || ch);
    expq.push_back(model(fifo_word, bit_mode, pk_eff, ch, fifo_empty));
    tagq.push_back(tag);
    #1;
    check({tag, " pop (R10)"}, {36'h0, fifo_pop}, {36'h0, exp_pop});
    @(posedge clk);
    #1;
    req = 1'b0;
    if (exp_pop) void'(hq.pop_front());
    refresh();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (sf_valid) begin
        if (expq.size() == 0) check("R10 unexpected valid", 37'h1, 37'h0);
        else check(tagq.pop_front(), pack_obs(), expq.pop_front());
      end else begin
        check("R9 underrun idle", {36'h0, underrun}, 37'h0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    refresh();
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {sf_valid, pack_obs()[35:0]}, 37'h0);
    check("R11 reset underrun", {36'h0, underrun}, 37'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {sf_valid, pack_obs()[35:0]}, 37'h0);

    bit_mode = 2'd2; hq.push_back(32'hAB12_3456); hq.push_back(32'hFF80_0001); refresh();
    do_sf(1'b0, "R1 24-bit left");
    do_sf(1'b1, "R1 24-bit right R8");

    bit_mode = 2'd0; hq.push_back(32'hFFFF_8001); hq.push_back(32'h1234_7FFF); refresh();
    do_sf(1'b0, "R2 16-bit upper ignored");
    do_sf(1'b1, "R2 16-bit right R7");

    bit_mode = 2'd1; hq.push_back(32'hFFF9_ABCD); hq.push_back(32'h0000_0001); refresh();
    do_sf(1'b0, "R3 20-bit");
    do_sf(1'b1, "R3 20-bit parity R7");

    bit_mode = 2'd3;
    hq.push_back(32'hA123_4567); hq.push_back(32'h5FED_CBA9); hq.push_back(32'h0000_0000);
    refresh();
    do_sf(1'b0, "R4 raw pass");
    do_sf(1'b1, "R4 raw bad parity kept");
    do_sf(1'b1, "R4 raw zero preamble");

    bit_mode = 2'd0; pack = 1'b1;
    hq.push_back(32'h1111_2222); hq.push_back(32'hC0DE_BEEF); refresh();
    do_sf(1'b0, "R5 packed left");
    do_sf(1'b1, "R5 packed right");
    do_sf(1'b0, "R5 packed left 2");
    do_sf(1'b1, "R5 packed right 2");

    bit_mode = 2'd2;
    hq.push_back(32'h7765_4321); hq.push_back(32'h00AB_CDEF); refresh();
    do_sf(1'b0, "R6 pack ignored 24-bit");
    do_sf(1'b0, "R6 second word popped");

    do_sf(1'b0, "R9 underrun left");
    do_sf(1'b1, "R9 underrun right R8");
    bit_mode = 2'd0;
    do_sf(1'b0, "R9 underrun packed");
    bit_mode = 2'd3; pack = 1'b0;
    do_sf(1'b1, "R9 underrun raw");
    hq.push_back(32'h0123_4560); refresh();
    do_sf(1'b0, "R4 raw after underrun");

    repeat (3) @(negedge clk);
    check("R9 queue drained", {5'h0, hq.size()}, 37'h0);
    check("R10 all subframes seen", {5'h0, expq.size()}, 37'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule